// File: doc/BRIEF.md
# Configurable GPIO Pin Control Port

This block is a register-programmed general-purpose I/O port for a group of pins (eight by default). A simple synchronous bus with an address, a write strobe, write data and combinational read data gives access to a set of per-pin configuration registers. These registers hold direction, output level, pull-resistor enable and a two-bit function select made up of a low select register and a high select register. From them the block drives four pad controls for each pin: output enable, output value, pull enable and pull direction.

The output-level register has two jobs. When a pin drives, it sets the level on the pin. When the pin's pull resistor is enabled, it chooses between pull-up and pull-down. The function select sends either the port's own output level or one of two peripheral output lines to the pad. The direction register alone sets the output enable, whatever function is selected.

Pin inputs pass through a two-stage synchronizer clocked by the bus clock. The synchronized state can be read at the input address.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After a synchronous reset every register reads 0 at every address 0 to 7. The input address also reads 0 until pin data has passed the synchronizer, and pad_oe, pad_out, pad_pull_en and pad_pull_up are all 0.
- R2: Writes to address 1 (output level), 2 (direction), 3 (pull enable), 4 (select low) and 5 (select high) are stored on the clock edge. The written value reads back at the same address from the next cycle on.
- R3: Address 0 returns the pin levels (bit i = pin i, 1 = high) after two clock edges of synchronization. A pin change is not visible after only one edge.
- R4: A write to address 0, or to the unmapped addresses 6 and 7, changes no register. Addresses 6 and 7 read 0.
- R5: pad_oe bit i equals direction bit i (1 = drive) for every function select code.
- R6: With select code {select high, select low} = 00 on a pin, pad_out follows that pin's output-level bit.
- R7: Select code 01 routes the primary peripheral's output line pri_out to pad_out. Code 11 routes the secondary line sec_out. Here code = {select-low bit, select-high bit}, so 01 means select low 0 and select high 1.
- R8: The reserved code 10 (select low 1, select high 0) behaves like code 00: pad_out follows the output-level bit and ignores the peripheral lines.
- R9: pad_pull_en bit i equals pull-enable bit i. While it is 1, pad_pull_up equals the output-level bit (1 = pull-up, 0 = pull-down). While it is 0, pad_pull_up is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Asynchronous pin levels from the pads |
| pri_out | input | 8 | Primary peripheral output, one bit per pin |
| sec_out | input | 8 | Secondary peripheral output, one bit per pin |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pull_en | output | 8 | Pad pull-resistor enable |
| pad_pull_up | output | 8 | Pad pull direction, 1 = up |

## Verification
The assertions assume the following about the inputs:
- The bus address, write strobe and write data are stable around each rising edge.
- pin_in changes no more than once per cycle, as a level that the first synchronizer stage can capture.

The stimulus meets these conditions by driving every input just after a rising edge and sampling only at falling edges. The peripheral lines are driven as ordinary levels, and they are inverted between checks so that routing through the wrong path shows up.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int GPIO_PINS   = 8;
    localparam int GPIO_ADDR_W = 3;

    // Register addresses
    localparam int ADR_PINLVL = 0;
    localparam int ADR_LEVEL  = 1;
    localparam int ADR_DRIVE  = 2;
    localparam int ADR_PULLON = 3;
    localparam int ADR_FSEL_L = 4;
    localparam int ADR_FSEL_H = 5;

    typedef enum logic [1:0] {
        FN_PORT     = 2'b00,
        FN_PRIMARY  = 2'b01,
        FN_RESERVED = 2'b10,
        FN_SECOND   = 2'b11
    } pin_fn_e;

    typedef struct packed {
        logic oe;
        logic val;
        logic pull_en;
        logic pull_up;
    } pad_ctl_t;

    function automatic pin_fn_e decode_fn(input logic sel_lo, input logic sel_hi);
        return pin_fn_e'({sel_lo, sel_hi});
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] pin_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pin_async;
            stage2_q <= stage1_q;
        end
    end

    assign pin_sync = stage2_q;

    // Set from the second edge after reset on, so that $past never looks at reset-time values
    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    a_r3_first_stage: assert property (@(posedge clk) disable iff (rst)
        live_q |-> stage1_q == $past(pin_async));
    a_r3_second_stage: assert property (@(posedge clk) disable iff (rst)
        live_q |-> pin_sync == $past(stage1_q));

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_sync,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  level_q,
    output logic [W-1:0]  drive_q,
    output logic [W-1:0]  pullon_q,
    output logic [W-1:0]  fsel_lo_q,
    output logic [W-1:0]  fsel_hi_q
);
    import gpio_port_pkg::*;

    localparam logic [AW-1:0] A_PIN  = AW'(ADR_PINLVL);
    localparam logic [AW-1:0] A_LVL  = AW'(ADR_LEVEL);
    localparam logic [AW-1:0] A_DRV  = AW'(ADR_DRIVE);
    localparam logic [AW-1:0] A_PUL  = AW'(ADR_PULLON);
    localparam logic [AW-1:0] A_FSL  = AW'(ADR_FSEL_L);
    localparam logic [AW-1:0] A_FSH  = AW'(ADR_FSEL_H);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= '0;
            drive_q   <= '0;
            pullon_q  <= '0;
            fsel_lo_q <= '0;
            fsel_hi_q <= '0;
        end else if (we) begin
            case (addr)
                A_LVL:   level_q   <= wdata;
                A_DRV:   drive_q   <= wdata;
                A_PUL:   pullon_q  <= wdata;
                A_FSL:   fsel_lo_q <= wdata;
                A_FSH:   fsel_hi_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_PIN:   rdata = pin_sync;
            A_LVL:   rdata = level_q;
            A_DRV:   rdata = drive_q;
            A_PUL:   rdata = pullon_q;
            A_FSL:   rdata = fsel_lo_q;
            A_FSH:   rdata = fsel_hi_q;
            default: rdata = '0;
        endcase
    end

    a_r1_regs_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (level_q == '0 && drive_q == '0 && pullon_q == '0
                        && fsel_lo_q == '0 && fsel_hi_q == '0));

    a_r2_level_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_LVL) |=> level_q == $past(wdata));

    a_r2_drive_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_DRV) |=> drive_q == $past(wdata));

    a_r4_pin_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && (addr == A_PIN || addr > A_FSH)) |=>
            ($stable(level_q) && $stable(drive_q) && $stable(pullon_q)
             && $stable(fsel_lo_q) && $stable(fsel_hi_q)));

endmodule

// File: rtl/gpio_pad_route.sv
module gpio_pad_route #(
    parameter int W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [W-1:0]                level,
    input  logic [W-1:0]                drive,
    input  logic [W-1:0]                pullon,
    input  logic [W-1:0]                fsel_lo,
    input  logic [W-1:0]                fsel_hi,
    input  logic [W-1:0]                pri_out,
    input  logic [W-1:0]                sec_out,
    output gpio_port_pkg::pad_ctl_t [W-1:0] pad
);
    import gpio_port_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_fn_e fn;
        assign fn = decode_fn(fsel_lo[i], fsel_hi[i]);

        always_comb begin
            pad[i].oe      = drive[i];
            pad[i].pull_en = pullon[i];
            pad[i].pull_up = pullon[i] & level[i];
            case (fn)
                FN_PRIMARY: pad[i].val = pri_out[i];
                FN_SECOND:  pad[i].val = sec_out[i];
                default:    pad[i].val = level[i];
            endcase
        end

        a_r7_primary_path: assert property (@(posedge clk) disable iff (rst)
            (!fsel_lo[i] && fsel_hi[i]) |-> pad[i].val == pri_out[i]);
        a_r7_secondary_path: assert property (@(posedge clk) disable iff (rst)
            (fsel_lo[i] && fsel_hi[i]) |-> pad[i].val == sec_out[i]);
        a_r8_port_path: assert property (@(posedge clk) disable iff (rst)
            !fsel_hi[i] |-> pad[i].val == level[i]);
        a_r9_no_pull_dir: assert property (@(posedge clk) disable iff (rst)
            !pad[i].pull_en |-> !pad[i].pull_up);
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
    parameter int PIN_W  = gpio_port_pkg::GPIO_PINS,
    parameter int ADDR_W = gpio_port_pkg::GPIO_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    input  logic [PIN_W-1:0]  pri_out,
    input  logic [PIN_W-1:0]  sec_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_pull_en,
    output logic [PIN_W-1:0]  pad_pull_up
);
    import gpio_port_pkg::*;

    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] level_q, drive_q, pullon_q, fsel_lo_q, fsel_hi_q;
    pad_ctl_t [PIN_W-1:0] pad;

    gpio_in_sync #(.W(PIN_W)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_in),
        .pin_sync  (pin_sync)
    );

    gpio_cfg_regs #(.W(PIN_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .pin_sync  (pin_sync),
        .rdata     (bus_rdata),
        .level_q   (level_q),
        .drive_q   (drive_q),
        .pullon_q  (pullon_q),
        .fsel_lo_q (fsel_lo_q),
        .fsel_hi_q (fsel_hi_q)
    );

    gpio_pad_route #(.W(PIN_W)) u_route (
        .clk     (clk),
        .rst     (rst),
        .level   (level_q),
        .drive   (drive_q),
        .pullon  (pullon_q),
        .fsel_lo (fsel_lo_q),
        .fsel_hi (fsel_hi_q),
        .pri_out (pri_out),
        .sec_out (sec_out),
        .pad     (pad)
    );

    for (genvar i = 0; i < PIN_W; i++) begin : g_unpack
        assign pad_oe[i]      = pad[i].oe;
        assign pad_out[i]     = pad[i].val;
        assign pad_pull_en[i] = pad[i].pull_en;
        assign pad_pull_up[i] = pad[i].pull_up;
    end

    a_r5_oe_tracks_drive_reg: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(ADR_DRIVE)) |=> pad_oe == $past(bus_wdata));

endmodule

// File: tb/gpio_pin_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = 8'hA5;
    logic [W-1:0] pri_out = '0;
    logic [W-1:0] sec_out = '0;
    logic [W-1:0] pad_oe, pad_out, pad_pull_en, pad_pull_up;

    always #2.5 clk = ~clk;

    gpio_pin_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_in      (pin_in),
        .pri_out     (pri_out),
        .sec_out     (sec_out),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up)
    );

    // Kinds of observation: 0 rdata, 1 oe, 2 out, 3 pull_en, 4 pull_up
    typedef struct {
        int           kind;
        logic [W-1:0] exp;
        string        req;
    } item_t;

    item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Monitor: pops and compares at falling edges
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [W-1:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = pad_oe;
                    2: act = pad_out;
                    3: act = pad_pull_en;
                    default: act = pad_pull_up;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        step();
        bus_we    = 1'b0;
    endtask

    task automatic push(input int kind, input logic [W-1:0] e, input string req);
        item_t it;
        it.kind = kind;
        it.exp  = e;
        it.req  = req;
        sb_q.push_back(it);
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [W-1:0] e, input string req);
        bus_addr = a;
        push(0, e, req);
        @(negedge clk);
        #1;
    endtask

    task automatic exp_pad(input int kind, input logic [W-1:0] e, input string req);
        push(kind, e, req);
        @(negedge clk);
        #1;
    endtask

    // Pad value model from R6, R7 and R8
    function automatic logic [W-1:0] model_out(input logic [W-1:0] lo, input logic [W-1:0] hi,
                                               input logic [W-1:0] lvl, input logic [W-1:0] p,
                                               input logic [W-1:0] s);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (hi[i]) r[i] = lo[i] ? s[i] : p[i];
            else       r[i] = lvl[i];
        end
        return r;
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;
        // R1: reset state, including the input address before the synchronizer has filled
        exp_rd(3'd0, 8'h00, "R1");
        for (int a = 1; a < 8; a++) exp_rd(3'(a), 8'h00, "R1");
        exp_pad(1, 8'h00, "R1");
        exp_pad(2, 8'h00, "R1");
        exp_pad(3, 8'h00, "R1");
        exp_pad(4, 8'h00, "R1");

        // R3: synchronized input
        step(); step();
        exp_rd(3'd0, 8'hA5, "R3");
        step();
        pin_in = 8'h3C;
        bus_addr = 3'd0;
        step();
        exp_rd(3'd0, 8'hA5, "R3");
        step();
        exp_rd(3'd0, 8'h3C, "R3");

        // R2: write then read back
        wr(3'd1, 8'h5A); exp_rd(3'd1, 8'h5A, "R2");
        wr(3'd2, 8'hC3); exp_rd(3'd2, 8'hC3, "R2");
        wr(3'd3, 8'h0F); exp_rd(3'd3, 8'h0F, "R2");
        wr(3'd4, 8'h33); exp_rd(3'd4, 8'h33, "R2");
        wr(3'd5, 8'h55); exp_rd(3'd5, 8'h55, "R2");

        // R4: writes to the input and unmapped addresses are ignored
        wr(3'd0, 8'hFF);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hEE);
        exp_rd(3'd1, 8'h5A, "R4");
        exp_rd(3'd2, 8'hC3, "R4");
        exp_rd(3'd3, 8'h0F, "R4");
        exp_rd(3'd4, 8'h33, "R4");
        exp_rd(3'd5, 8'h55, "R4");
        exp_rd(3'd6, 8'h00, "R4");
        exp_rd(3'd7, 8'h00, "R4");
        exp_rd(3'd0, 8'h3C, "R4");

        // R6 R7 R8: mixed select codes per pin
        wr(3'd2, 8'hFF);
        wr(3'd1, 8'hA5);
        wr(3'd4, 8'h0F);
        wr(3'd5, 8'h33);
        pri_out = 8'h96; sec_out = 8'h69;
        exp_pad(2, model_out(8'h0F, 8'h33, 8'hA5, 8'h96, 8'h69), "R7");
        pri_out = 8'h69; sec_out = 8'h96;
        exp_pad(2, model_out(8'h0F, 8'h33, 8'hA5, 8'h69, 8'h96), "R7");
        // R6: all pins on code 00
        wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        exp_pad(2, 8'hA5, "R6");
        // R8: all pins on the reserved code
        wr(3'd4, 8'hFF);
        pri_out = 8'h00; sec_out = 8'hFF;
        exp_pad(2, 8'hA5, "R8");
        pri_out = 8'hFF; sec_out = 8'h00;
        exp_pad(2, 8'hA5, "R8");
        // R7: every pin on the primary path, then on the secondary path
        wr(3'd4, 8'h00); wr(3'd5, 8'hFF);
        exp_pad(2, 8'hFF, "R7");
        wr(3'd4, 8'hFF);
        exp_pad(2, 8'h00, "R7");

        // R5: output enable under peripheral selection
        wr(3'd2, 8'h3C);
        exp_pad(1, 8'h3C, "R5");
        wr(3'd4, 8'h0F); wr(3'd5, 8'h33);
        exp_pad(1, 8'h3C, "R5");

        // R9: pull control
        wr(3'd3, 8'hF0);
        exp_pad(3, 8'hF0, "R9");
        exp_pad(4, 8'hA0, "R9");
        wr(3'd1, 8'h5A);
        exp_pad(4, 8'h50, "R9");
        wr(3'd3, 8'h00);
        exp_pad(3, 8'h00, "R9");
        exp_pad(4, 8'h00, "R9");

        step(); step();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule